// File: doc/BRIEF.md
# DSI Sync-Pulse Video Line Sequencer

This block generates the byte stream of a display serial link running video mode with sync pulses. Every line is assembled from a fixed sequence of six packets: a horizontal (or vertical) sync-start short packet, a sync-width blanking long packet, a sync-end short packet, a back-porch blanking long packet, the active long packet, and a front-porch blanking long packet. Each blanking and active long packet has a word count that software programs. The vertical frame consists of sync, back-porch, active and front-porch regions, and each region has a programmed line count. Outside the active region, the active packet becomes a blanking packet of the same length, so every line in a frame has the same byte total.

The core clock advances one byte of the aggregate stream per cycle. Pixel bytes arrive through a byte-wide valid/ready input and are only taken inside the payload of active lines. A lane packer deals the bytes round-robin over `LANES` lanes. A line always starts on lane 0. When a line's byte total is not a multiple of the lane count, the last lane word of the line is padded with idle lanes. Checksum and ECC fields are left as zero placeholders for a later stage to fill in. The programmed timing is latched into shadow registers once per frame, and the latched values apply to the whole next frame.

Top module: `dsi_line_seq`

## Requirements
- R1: Each line emits, in this order: sync-start short, sync-width long (word count HSA), sync-end short, back-porch long (HBP), active long (HACT), front-porch long (HFP).
- R2: A short packet is 4 bytes: data type, 0x00, 0x00, 0x00 (ECC placeholder).
- R3: A long packet is the data type, word count low byte, word count high byte, 0x00, then word-count payload bytes, then two 0x00 checksum placeholders; a word count of zero gives a 6-byte packet.
- R4: On sync-region lines the short packets use codes 0x01 (start) and 0x11 (end); on all other lines they use 0x21 and 0x31.
- R5: On active-region lines the active packet uses the pixel data type `PIX_DT` (default 0x0B) and carries the pixel input bytes in order. On other lines it uses the blanking type 0x19 with word count HACT and zero payload. Every line of a frame has the same number of lane words.
- R6: A frame runs sync, back-porch, active, front-porch regions in that order with the programmed line counts; a count of zero is taken as one line.
- R7: Byte n of a line goes to lane n mod LANES, at bits [8*lane+7:8*lane] of `lane_data`; `lane_en` marks the lanes that carry bytes, and idle lanes of a line's last word read 0x00 with their enable low.
- R8: `lane_sol` is high on the first lane word of every line; `lane_sof` is high only on the first lane word of a frame.
- R9: If a pixel byte is due and `pix_valid` is low, the stream holds without skipping or inventing bytes, and `underflow` goes high and stays high until reset.
- R10: Timing inputs are sampled once when a frame starts; changes made mid-frame first show in the next frame.
- R11: During reset `lane_valid`, `pix_ready` and `underflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Aggregate byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hsa | input | HW | Sync-width payload word count |
| cfg_hbp | input | HW | Back-porch payload word count |
| cfg_hact | input | HW | Active payload word count |
| cfg_hfp | input | HW | Front-porch payload word count |
| cfg_vsa | input | VW | Sync-region line count |
| cfg_vbp | input | VW | Back-porch line count |
| cfg_vact | input | VW | Active line count |
| cfg_vfp | input | VW | Front-porch line count |
| pix_data | input | 8 | Pixel byte |
| pix_valid | input | 1 | Pixel byte available |
| pix_ready | output | 1 | Pixel byte taken this cycle |
| lane_valid | output | 1 | Lane word present |
| lane_data | output | 8*LANES | Bytes per lane |
| lane_en | output | LANES | Lanes that carry a byte |
| lane_sol | output | 1 | First word of a line |
| lane_sof | output | 1 | First word of a frame |
| underflow | output | 1 | Sticky pixel starvation flag |

## Verification
A wrong packet segment or byte position counter corrupts a header or shifts the payload. This appears in the next lane word after the bad byte. A bad vertical region or line counter shows up at the next line boundary as wrong short-packet codes, a wrong active data type or the wrong number of lines per frame. A packer index fault breaks the `lane_en` shape or moves a byte to the wrong lane within one word. A stall fault drops or repeats a pixel byte, and the ordered pixel payload exposes it in the first affected word.

// File: rtl/dsi_seq_pkg.sv
package dsi_seq_pkg;
  typedef enum logic [2:0] {
    SEG_SS  = 3'd0,
    SEG_SA  = 3'd1,
    SEG_SE  = 3'd2,
    SEG_BP  = 3'd3,
    SEG_ACT = 3'd4,
    SEG_FP  = 3'd5
  } seg_e;

  typedef enum logic [1:0] {
    VR_SYNC  = 2'd0,
    VR_BACK  = 2'd1,
    VR_ACT   = 2'd2,
    VR_FRONT = 2'd3
  } vreg_e;

  localparam logic [7:0] DT_VSYNC_ON  = 8'h01;
  localparam logic [7:0] DT_VSYNC_OFF = 8'h11;
  localparam logic [7:0] DT_HSYNC_ON  = 8'h21;
  localparam logic [7:0] DT_HSYNC_OFF = 8'h31;
  localparam logic [7:0] DT_BLANK     = 8'h19;
endpackage

// File: rtl/dsi_vtiming.sv
module dsi_vtiming
  import dsi_seq_pkg::*;
#(
  parameter int HW = 16,
  parameter int VW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_done,
  input  logic [HW-1:0] cfg_hsa,
  input  logic [HW-1:0] cfg_hbp,
  input  logic [HW-1:0] cfg_hact,
  input  logic [HW-1:0] cfg_hfp,
  input  logic [VW-1:0] cfg_vsa,
  input  logic [VW-1:0] cfg_vbp,
  input  logic [VW-1:0] cfg_vact,
  input  logic [VW-1:0] cfg_vfp,
  output logic          run,
  output vreg_e         region,
  output logic          frame_first,
  output logic [HW-1:0] sh_hsa,
  output logic [HW-1:0] sh_hbp,
  output logic [HW-1:0] sh_hact,
  output logic [HW-1:0] sh_hfp
);
  logic          loaded_q, loaded_d;
  vreg_e         region_q, region_d;
  logic [VW-1:0] lcnt_q, lcnt_d;
  logic [HW-1:0] hsa_q, hbp_q, hact_q, hfp_q;
  logic [HW-1:0] hsa_d, hbp_d, hact_d, hfp_d;
  logic [VW-1:0] vsa_q, vbp_q, vact_q, vfp_q;
  logic [VW-1:0] vsa_d, vbp_d, vact_d, vfp_d;
  logic [VW-1:0] cur_cnt, span;
  logic          load;

  always_comb begin
    case (region_q)
      VR_SYNC:  cur_cnt = vsa_q;
      VR_BACK:  cur_cnt = vbp_q;
      VR_ACT:   cur_cnt = vact_q;
      default:  cur_cnt = vfp_q;
    endcase
    span = (cur_cnt == '0) ? VW'(1) : cur_cnt;
  end

  always_comb begin
    loaded_d = loaded_q;
    region_d = region_q;
    lcnt_d   = lcnt_q;
    load     = 1'b0;
    if (!loaded_q) begin
      loaded_d = 1'b1;
      load     = 1'b1;
      region_d = VR_SYNC;
      lcnt_d   = '0;
    end else if (line_done) begin
      if (lcnt_q == span - VW'(1)) begin
        lcnt_d = '0;
        case (region_q)
          VR_SYNC:  region_d = VR_BACK;
          VR_BACK:  region_d = VR_ACT;
          VR_ACT:   region_d = VR_FRONT;
          default: begin
            region_d = VR_SYNC;
            load     = 1'b1;
          end
        endcase
      end else begin
        lcnt_d = lcnt_q + VW'(1);
      end
    end
    hsa_d  = load ? cfg_hsa  : hsa_q;
    hbp_d  = load ? cfg_hbp  : hbp_q;
    hact_d = load ? cfg_hact : hact_q;
    hfp_d  = load ? cfg_hfp  : hfp_q;
    vsa_d  = load ? cfg_vsa  : vsa_q;
    vbp_d  = load ? cfg_vbp  : vbp_q;
    vact_d = load ? cfg_vact : vact_q;
    vfp_d  = load ? cfg_vfp  : vfp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      region_q <= VR_SYNC;
      lcnt_q   <= '0;
      hsa_q    <= '0;
      hbp_q    <= '0;
      hact_q   <= '0;
      hfp_q    <= '0;
      vsa_q    <= '0;
      vbp_q    <= '0;
      vact_q   <= '0;
      vfp_q    <= '0;
    end else begin
      loaded_q <= loaded_d;
      region_q <= region_d;
      lcnt_q   <= lcnt_d;
      hsa_q    <= hsa_d;
      hbp_q    <= hbp_d;
      hact_q   <= hact_d;
      hfp_q    <= hfp_d;
      vsa_q    <= vsa_d;
      vbp_q    <= vbp_d;
      vact_q   <= vact_d;
      vfp_q    <= vfp_d;
    end
  end

  assign run         = loaded_q;
  assign region      = region_q;
  assign frame_first = (region_q == VR_SYNC) && (lcnt_q == '0);
  assign sh_hsa      = hsa_q;
  assign sh_hbp      = hbp_q;
  assign sh_hact     = hact_q;
  assign sh_hfp      = hfp_q;
endmodule

// File: rtl/dsi_pkt_engine.sv
module dsi_pkt_engine
  import dsi_seq_pkg::*;
#(
  parameter int         HW     = 16,
  parameter logic [7:0] PIX_DT = 8'h0B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  vreg_e         region,
  input  logic [HW-1:0] hsa,
  input  logic [HW-1:0] hbp,
  input  logic [HW-1:0] hact,
  input  logic [HW-1:0] hfp,
  input  logic [7:0]    pix_data,
  input  logic          pix_valid,
  output logic          pix_ready,
  output logic          byte_vld,
  output logic [7:0]    byte_dat,
  output logic          byte_first,
  output logic          byte_last,
  output logic          underflow
);
  localparam int PW = HW + 1;

  seg_e          seg_q, seg_d;
  logic [PW-1:0] pos_q, pos_d;
  logic          unf_q, unf_d;
  logic [HW-1:0] wc;
  logic [15:0]   wc16;
  logic [PW-1:0] pay_end, plen;
  logic          is_long, at_last, in_pay, act_line, pix_phase, stall, adv;
  logic [7:0]    dt;

  always_comb begin
    is_long = (seg_q != SEG_SS) && (seg_q != SEG_SE);
    case (seg_q)
      SEG_SA:  wc = hsa;
      SEG_BP:  wc = hbp;
      SEG_ACT: wc = hact;
      SEG_FP:  wc = hfp;
      default: wc = '0;
    endcase
    wc16      = 16'(wc);
    pay_end   = {1'b0, wc} + PW'(4);
    plen      = is_long ? (pay_end + PW'(2)) : PW'(4);
    at_last   = (pos_q == plen - PW'(1));
    in_pay    = is_long && (pos_q >= PW'(4)) && (pos_q < pay_end);
    act_line  = (region == VR_ACT);
    pix_phase = run && (seg_q == SEG_ACT) && act_line && in_pay;
    stall     = pix_phase && !pix_valid;
    adv       = run && !stall;
  end

  always_comb begin
    case (seg_q)
      SEG_SS:  dt = (region == VR_SYNC) ? DT_VSYNC_ON  : DT_HSYNC_ON;
      SEG_SE:  dt = (region == VR_SYNC) ? DT_VSYNC_OFF : DT_HSYNC_OFF;
      SEG_ACT: dt = act_line ? PIX_DT : DT_BLANK;
      default: dt = DT_BLANK;
    endcase
    if (pos_q == PW'(0))      byte_dat = dt;
    else if (pos_q == PW'(1)) byte_dat = is_long ? wc16[7:0]  : 8'h00;
    else if (pos_q == PW'(2)) byte_dat = is_long ? wc16[15:8] : 8'h00;
    else if (pix_phase)       byte_dat = pix_data;
    else                      byte_dat = 8'h00;
  end

  always_comb begin
    seg_d = seg_q;
    pos_d = pos_q;
    if (adv) begin
      if (at_last) begin
        pos_d = '0;
        seg_d = (seg_q == SEG_FP) ? SEG_SS : seg_e'(seg_q + 3'd1);
      end else begin
        pos_d = pos_q + PW'(1);
      end
    end
    unf_d = unf_q | stall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= SEG_SS;
      pos_q <= '0;
      unf_q <= 1'b0;
    end else begin
      seg_q <= seg_d;
      pos_q <= pos_d;
      unf_q <= unf_d;
    end
  end

  assign pix_ready  = pix_phase;
  assign byte_vld   = adv;
  assign byte_first = (seg_q == SEG_SS) && (pos_q == '0);
  assign byte_last  = adv && at_last && (seg_q == SEG_FP);
  assign underflow  = unf_q;
endmodule

// File: rtl/dsi_lane_pack.sv
module dsi_lane_pack #(
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               byte_vld,
  input  logic [7:0]         byte_dat,
  input  logic               byte_first,
  input  logic               byte_last,
  input  logic               frame_first,
  output logic               lane_valid,
  output logic [8*LANES-1:0] lane_data,
  output logic [LANES-1:0]   lane_en,
  output logic               lane_sol,
  output logic               lane_sof
);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LW-1:0]      gidx_q, gidx_d;
  logic [7:0]         hold_q [LANES];
  logic [7:0]         hold_d [LANES];
  logic               gsol_q, gsol_d, gsof_q, gsof_d;
  logic               flush, w_sol, w_sof;
  logic [8*LANES-1:0] w_dat;
  logic [LANES-1:0]   w_en;
  logic               v_q;
  logic [8*LANES-1:0] d_q;
  logic [LANES-1:0]   e_q;
  logic               s_q, f_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      if (LW'(i) < gidx_q)       w_dat[8*i +: 8] = hold_q[i];
      else if (LW'(i) == gidx_q) w_dat[8*i +: 8] = byte_dat;
      else                       w_dat[8*i +: 8] = 8'h00;
      w_en[i] = (LW'(i) <= gidx_q);
    end
  end

  always_comb begin
    flush  = byte_vld && ((gidx_q == LW'(LANES - 1)) || byte_last);
    w_sol  = (gidx_q == '0) ? byte_first : gsol_q;
    w_sof  = (gidx_q == '0) ? (byte_first && frame_first) : gsof_q;
    gidx_d = gidx_q;
    gsol_d = gsol_q;
    gsof_d = gsof_q;
    for (int i = 0; i < LANES; i++) hold_d[i] = hold_q[i];
    if (byte_vld) begin
      hold_d[gidx_q] = byte_dat;
      gsol_d = w_sol;
      gsof_d = w_sof;
      gidx_d = flush ? '0 : gidx_q + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gidx_q <= '0;
      gsol_q <= 1'b0;
      gsof_q <= 1'b0;
      for (int i = 0; i < LANES; i++) hold_q[i] <= 8'h00;
      v_q    <= 1'b0;
      d_q    <= '0;
      e_q    <= '0;
      s_q    <= 1'b0;
      f_q    <= 1'b0;
    end else begin
      gidx_q <= gidx_d;
      gsol_q <= gsol_d;
      gsof_q <= gsof_d;
      for (int i = 0; i < LANES; i++) hold_q[i] <= hold_d[i];
      v_q <= flush;
      if (flush) begin
        d_q <= w_dat;
        e_q <= w_en;
        s_q <= w_sol;
        f_q <= w_sof;
      end
    end
  end

  assign lane_valid = v_q;
  assign lane_data  = d_q;
  assign lane_en    = e_q;
  assign lane_sol   = s_q;
  assign lane_sof   = f_q;
endmodule

// File: rtl/dsi_line_seq.sv
module dsi_line_seq
  import dsi_seq_pkg::*;
#(
  parameter int         LANES  = 2,
  parameter int         HW     = 16,
  parameter int         VW     = 12,
  parameter logic [7:0] PIX_DT = 8'h0B
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HW-1:0]      cfg_hsa,
  input  logic [HW-1:0]      cfg_hbp,
  input  logic [HW-1:0]      cfg_hact,
  input  logic [HW-1:0]      cfg_hfp,
  input  logic [VW-1:0]      cfg_vsa,
  input  logic [VW-1:0]      cfg_vbp,
  input  logic [VW-1:0]      cfg_vact,
  input  logic [VW-1:0]      cfg_vfp,
  input  logic [7:0]         pix_data,
  input  logic               pix_valid,
  output logic               pix_ready,
  output logic               lane_valid,
  output logic [8*LANES-1:0] lane_data,
  output logic [LANES-1:0]   lane_en,
  output logic               lane_sol,
  output logic               lane_sof,
  output logic               underflow
);
  logic          run, frame_first;
  vreg_e         region;
  logic [HW-1:0] sh_hsa, sh_hbp, sh_hact, sh_hfp;
  logic          b_vld, b_first, b_last;
  logic [7:0]    b_dat;

  dsi_vtiming #(.HW(HW), .VW(VW)) vtim_i (
    .clk(clk), .rst_n(rst_n), .line_done(b_last),
    .cfg_hsa(cfg_hsa), .cfg_hbp(cfg_hbp), .cfg_hact(cfg_hact), .cfg_hfp(cfg_hfp),
    .cfg_vsa(cfg_vsa), .cfg_vbp(cfg_vbp), .cfg_vact(cfg_vact), .cfg_vfp(cfg_vfp),
    .run(run), .region(region), .frame_first(frame_first),
    .sh_hsa(sh_hsa), .sh_hbp(sh_hbp), .sh_hact(sh_hact), .sh_hfp(sh_hfp)
  );

  dsi_pkt_engine #(.HW(HW), .PIX_DT(PIX_DT)) eng_i (
    .clk(clk), .rst_n(rst_n), .run(run), .region(region),
    .hsa(sh_hsa), .hbp(sh_hbp), .hact(sh_hact), .hfp(sh_hfp),
    .pix_data(pix_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .byte_vld(b_vld), .byte_dat(b_dat), .byte_first(b_first), .byte_last(b_last),
    .underflow(underflow)
  );

  dsi_lane_pack #(.LANES(LANES)) pack_i (
    .clk(clk), .rst_n(rst_n), .byte_vld(b_vld), .byte_dat(b_dat),
    .byte_first(b_first), .byte_last(b_last), .frame_first(frame_first),
    .lane_valid(lane_valid), .lane_data(lane_data), .lane_en(lane_en),
    .lane_sol(lane_sol), .lane_sof(lane_sof)
  );
endmodule

// File: rtl/dsi_line_seq_chk.sv
module dsi_line_seq_chk #(
  parameter int LANES = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pix_valid,
  input logic               pix_ready,
  input logic               lane_valid,
  input logic [8*LANES-1:0] lane_data,
  input logic [LANES-1:0]   lane_en,
  input logic               lane_sol,
  input logic               lane_sof,
  input logic               underflow
);
  logic [8*LANES-1:0] idle_mask;
  logic               en_gap;

  for (genvar i = 0; i < LANES; i++) begin : g_mask
    assign idle_mask[8*i +: 8] = {8{~lane_en[i]}};
  end
  assign en_gap = |(lane_en & (lane_en + LANES'(1)));

  a_r7_en_shape: assert property (@(posedge clk) disable iff (!rst_n)
    lane_valid |-> (lane_en[0] && !en_gap));

  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    lane_valid |-> ((lane_data & idle_mask) == '0));

  a_r8_frame_is_line: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_valid && lane_sof) |-> lane_sol);

  a_r9_gap_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ready && !pix_valid) |=> underflow);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
endmodule

bind dsi_line_seq dsi_line_seq_chk #(.LANES(LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
  .lane_valid(lane_valid), .lane_data(lane_data), .lane_en(lane_en),
  .lane_sol(lane_sol), .lane_sof(lane_sof), .underflow(underflow)
);

// File: tb/dsi_line_seq_tb.sv
module dsi_line_seq_tb_top;
  localparam int         LANES   = 2;
  localparam int         HW      = 16;
  localparam int         VW      = 12;
  localparam logic [7:0] PIX_DT  = 8'h0B;
  localparam time        CLK_PER = 10ns;

  typedef struct packed {
    logic [8*LANES-1:0] d;
    logic [LANES-1:0]   en;
    logic               sol;
    logic               sof;
  } word_t;

  typedef struct {
    int hsa, hbp, hact, hfp, vsa, vbp, vact, vfp;
  } tcfg_t;

  logic clk, rst_n;
  logic [HW-1:0] cfg_hsa, cfg_hbp, cfg_hact, cfg_hfp;
  logic [VW-1:0] cfg_vsa, cfg_vbp, cfg_vact, cfg_vfp;
  logic [7:0] pix_data;
  logic pix_valid, pix_ready, lane_valid, lane_sol, lane_sof, underflow;
  logic [8*LANES-1:0] lane_data;
  logic [LANES-1:0] lane_en;

  dsi_line_seq #(.LANES(LANES), .HW(HW), .VW(VW), .PIX_DT(PIX_DT)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_hsa(cfg_hsa), .cfg_hbp(cfg_hbp), .cfg_hact(cfg_hact), .cfg_hfp(cfg_hfp),
    .cfg_vsa(cfg_vsa), .cfg_vbp(cfg_vbp), .cfg_vact(cfg_vact), .cfg_vfp(cfg_vfp),
    .pix_data(pix_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .lane_valid(lane_valid), .lane_data(lane_data), .lane_en(lane_en),
    .lane_sol(lane_sol), .lane_sof(lane_sof), .underflow(underflow)
  );

  initial clk = 1'b0;
  always #(CLK_PER / 2) clk = ~clk;

  // pixel source: incrementing bytes, optional gaps
  logic [31:0] pix_seq;
  int gcnt;
  bit gap_on;
  assign pix_data = pix_seq[7:0];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_seq <= '0;
    else if (pix_valid && pix_ready) pix_seq <= pix_seq + 1;
  end
  always @(negedge clk) begin
    gcnt <= gcnt + 1;
    pix_valid <= gap_on ? ((gcnt % 3) != 0) : 1'b1;
  end

  // expected model
  word_t exp_q[$];
  logic [7:0] lb[$];
  int exp_pix;

  task automatic put_short(input logic [7:0] dt);
    lb.push_back(dt); lb.push_back(8'h00); lb.push_back(8'h00); lb.push_back(8'h00);
  endtask

  task automatic put_long(input logic [7:0] dt, input int wc, input bit pix);
    lb.push_back(dt); lb.push_back(wc[7:0]); lb.push_back(wc[15:8]); lb.push_back(8'h00);
    for (int k = 0; k < wc; k++) begin
      if (pix) begin lb.push_back(exp_pix[7:0]); exp_pix++; end
      else lb.push_back(8'h00);
    end
    lb.push_back(8'h00); lb.push_back(8'h00);
  endtask

  // R1 packet order, R4 sync codes, R5 active or blanking
  task automatic push_line(input int reg_id, input tcfg_t c, input bit first);
    word_t w;
    bit vs, act;
    vs  = (reg_id == 0);
    act = (reg_id == 2);
    lb.delete();
    put_short(vs ? 8'h01 : 8'h21);
    put_long(8'h19, c.hsa, 1'b0);
    put_short(vs ? 8'h11 : 8'h31);
    put_long(8'h19, c.hbp, 1'b0);
    put_long(act ? PIX_DT : 8'h19, c.hact, act);
    put_long(8'h19, c.hfp, 1'b0);
    for (int i = 0; i < lb.size(); i += LANES) begin
      w = '0;
      w.sol = (i == 0);
      w.sof = (i == 0) && first;
      for (int l = 0; l < LANES; l++) begin
        if (i + l < lb.size()) begin
          w.d[8*l +: 8] = lb[i + l];
          w.en[l] = 1'b1;
        end
      end
      exp_q.push_back(w);
    end
  endtask

  // R6 region order and counts
  task automatic push_frame(input tcfg_t c);
    int cnt[4];
    bit first;
    cnt[0] = c.vsa; cnt[1] = c.vbp; cnt[2] = c.vact; cnt[3] = c.vfp;
    first = 1'b1;
    for (int r = 0; r < 4; r++) begin
      for (int n = 0; n < ((cnt[r] == 0) ? 1 : cnt[r]); n++) begin
        push_line(r, c, first);
        first = 1'b0;
      end
    end
  endtask

  task automatic apply_cfg(input tcfg_t c);
    cfg_hsa = HW'(c.hsa); cfg_hbp = HW'(c.hbp); cfg_hact = HW'(c.hact); cfg_hfp = HW'(c.hfp);
    cfg_vsa = VW'(c.vsa); cfg_vbp = VW'(c.vbp); cfg_vact = VW'(c.vact); cfg_vfp = VW'(c.vfp);
  endtask

  // scoreboard monitor
  bit mon_on;
  int mon_checks, mon_fails, mon_frames, cur_len, ref_len;
  bit have_ref;
  always @(negedge clk) begin
    if (mon_on && rst_n && lane_valid) begin
      word_t e;
      if (lane_sol) begin
        if (cur_len > 0) begin
          mon_checks++;
          if (have_ref && cur_len != ref_len) begin
            mon_fails++;
            $display("FAIL R5 line length act=%0d exp=%0d", cur_len, ref_len);
          end
          if (!have_ref) begin ref_len = cur_len; have_ref = 1'b1; end
        end
        if (lane_sof) begin have_ref = 1'b0; mon_frames++; end
        cur_len = 1;
      end else cur_len++;
      mon_checks++;
      if (exp_q.size() == 0) begin
        mon_fails++;
        $display("FAIL R6 extra lane word act=%h exp=none", lane_data);
      end else begin
        e = exp_q.pop_front();
        if (lane_data !== e.d) begin
          mon_fails++;
          $display("FAIL R1 R2 R3 R5 R10 data frame %0d act=%h exp=%h", mon_frames, lane_data, e.d);
        end else if (lane_en !== e.en) begin
          mon_fails++;
          $display("FAIL R7 lane_en act=%b exp=%b", lane_en, e.en);
        end else if (lane_sol !== e.sol || lane_sof !== e.sof) begin
          mon_fails++;
          $display("FAIL R8 sol/sof act=%b%b exp=%b%b", lane_sol, lane_sof, e.sol, e.sof);
        end
      end
    end
  end

  int checks, fails;
  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  initial begin
    tcfg_t ca, cb;
    int cyc;
    ca = '{hsa: 3, hbp: 2, hact: 5, hfp: 2, vsa: 1, vbp: 1, vact: 2, vfp: 1};
    cb = '{hsa: 0, hbp: 4, hact: 9, hfp: 2, vsa: 2, vbp: 0, vact: 3, vfp: 1};
    checks = 0; fails = 0; mon_checks = 0; mon_fails = 0; mon_frames = 0;
    cur_len = 0; ref_len = 0; have_ref = 1'b0; gcnt = 0;
    gap_on = 1'b0; mon_on = 1'b1; exp_pix = 0;
    rst_n = 1'b0;
    apply_cfg(ca);
    push_frame(ca);   // frame 0 with A (44 bytes per line, no pad)
    push_frame(cb);   // R10: B applies from frame 1 (47 bytes, padded)
    push_frame(cb);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(lane_valid == 1'b0, "R11 lane_valid in reset", int'(lane_valid), 0);
    chk(pix_ready == 1'b0, "R11 pix_ready in reset", int'(pix_ready), 0);
    chk(underflow == 1'b0, "R11 underflow in reset", int'(underflow), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    apply_cfg(cb);    // mid-frame change, R10
    cyc = 0;
    while (mon_frames < 2 && cyc < 20000) begin @(negedge clk); cyc++; end
    chk(underflow == 1'b0, "R9 no flag without gaps", int'(underflow), 0);
    gap_on = 1'b1;
    while (exp_q.size() != 0 && cyc < 20000) begin @(negedge clk); cyc++; end
    mon_on = 1'b0;
    chk(cyc < 20000, "R6 watchdog expired", cyc, 20000);
    chk(underflow == 1'b1, "R9 sticky flag after gaps", int'(underflow), 1);
    chk(mon_frames == 3, "R6 frame count", mon_frames, 3);
    chk(exp_pix == int'(pix_seq), "R9 pixels consumed", int'(pix_seq), exp_pix);
    repeat (20) @(negedge clk);
    chk(underflow == 1'b1, "R9 flag stays", int'(underflow), 1);
    $display("%0d/%0d checks passed", (checks + mon_checks) - (fails + mon_fails),
             checks + mon_checks);
    $finish;
  end
endmodule